// File: doc/BRIEF.md
# GPIO Bank Register Block with Masked Half-Word Writes

This block holds the control state for one 32-pin general-purpose I/O bank and sits behind a plain 32-bit register bus. Software drives pin values through an output register. The register can be written whole or through two half-word ports, one for pins 0–15 and one for pins 16–31. Each half-word port takes a per-bit protect mask in the upper half of the written word, so a single pin can be changed without reading the register first.

Two more registers set up each pin: one for direction and one for output enable. A pin is driven only when both of its bits are set. The pin levels pass through a two-stage synchronizer and can be read from a read-only register.

The `BANK` parameter moves the block's addresses to those of a given bank index. All registers clear on reset, so every pin starts as an undriven input.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, the output, direction and output-enable registers read 0, and the `pin_out` and `pin_oe` ports are all 0.
- R2: A write to the low masked port (address 8·BANK) works on pins 0–15 only. Bits [31:16] of the written word are a mask and bits [15:0] are the data. A pin takes its data bit where its mask bit is 0 and keeps its current value where its mask bit is 1. Pins 16–31 do not change. A read of this port returns 0.
- R3: A write to the high masked port (address 8·BANK+4) works in the same way on pins 16–31. Mask bit k and data bit k govern pin 16+k. Pins 0–15 do not change.
- R4: A write to the full output register (address 0x40+4·BANK) replaces all 32 output bits. A read of that address returns the register contents, which drive `pin_out`.
- R5: The direction register (address 0x204+0x40·BANK) and the output-enable register (address 0x208+0x40·BANK) read back exactly as written.
- R6: `pin_oe[i]` is 1 only when direction bit i is 1 (output) and output-enable bit i is 1. Otherwise the pin is tristated.
- R7: The input register (address 0x60+4·BANK) returns `pin_in` after two synchronizer stages. A change of `pin_in` is not seen by a read issued at the first clock edge after the change. Writes to the input register have no effect.
- R8: Reads of any unmapped address return 0. Writes to unmapped addresses change no register and no output port.
- R9: Every request (`bus_sel` high for one cycle) is answered by `bus_ready` high for exactly the following cycle, with read data valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | One-cycle acknowledge |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Output values |
| pin_oe | output | 32 | Per-pin drive enable |

## Verification
The bench uses masks that keep part of a half and take the rest, including a single-bit update and an all-ones mask that must leave every pin alone. A design that inverted the mask sense, or spilled a half-word write into the other half, would show wrong bits on `pin_out` and on the full-register readback. It reads the input register at the edge right after a pin change and again later. A one-stage synchronizer would show the new value too early. It also sets direction and output enable apart from each other, to catch a pin that is driven by either bit alone, and writes to unmapped and read-only addresses, where a loose decode would corrupt the outputs.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int ADDR_W = 12,
  parameter int BANK   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_ready,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pin_out,
  output logic [31:0]       pin_oe
);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(8 * BANK);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(8 * BANK + 4);
  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(32'h040 + 4 * BANK);
  localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(32'h060 + 4 * BANK);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(32'h204 + 32'h40 * BANK);
  localparam logic [ADDR_W-1:0] A_OEN = ADDR_W'(32'h208 + 32'h40 * BANK);

  logic [31:0] out_q, dir_q, oen_q, sync1_q, sync2_q, rd_mux;
  logic        wr;

  assign wr = bus_sel & bus_we;

  wire hit_lo  = bus_addr == A_LO;
  wire hit_hi  = bus_addr == A_HI;
  wire hit_out = bus_addr == A_OUT;
  wire hit_in  = bus_addr == A_IN;
  wire hit_dir = bus_addr == A_DIR;
  wire hit_oen = bus_addr == A_OEN;

  wire [15:0] keep = bus_wdata[31:16];
  wire [15:0] lo_new = (out_q[15:0]  & keep) | (bus_wdata[15:0] & ~keep);
  wire [15:0] hi_new = (out_q[31:16] & keep) | (bus_wdata[15:0] & ~keep);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
      oen_q <= '0;
    end else if (wr) begin
      if (hit_out) out_q <= bus_wdata;
      if (hit_lo)  out_q[15:0]  <= lo_new;
      if (hit_hi)  out_q[31:16] <= hi_new;
      if (hit_dir) dir_q <= bus_wdata;
      if (hit_oen) oen_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_out) rd_mux = out_q;
    if (hit_in)  rd_mux = sync2_q;
    if (hit_dir) rd_mux = dir_q;
    if (hit_oen) rd_mux = oen_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_ready <= 1'b0;
      bus_rdata <= '0;
    end else begin
      bus_ready <= bus_sel;
      bus_rdata <= (bus_sel && !bus_we) ? rd_mux : '0;
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q & oen_q;

  wire hit_any = hit_lo | hit_hi | hit_out | hit_in | hit_dir | hit_oen;

  assert_ready_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel |=> bus_ready);
  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bus_ready);
  assert_lo_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_lo) |=> (pin_out[31:16] == $past(pin_out[31:16])) &&
      (((pin_out[15:0] ^ $past(pin_out[15:0])) & $past(bus_wdata[31:16])) == 16'h0));
  assert_hi_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_hi) |=> (pin_out[15:0] == $past(pin_out[15:0])) &&
      (((pin_out[31:16] ^ $past(pin_out[31:16])) & $past(bus_wdata[31:16])) == 16'h0));
  assert_dir_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_dir && bus_wdata == 32'h0) |=> pin_oe == 32'h0);
  assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !hit_any) |=> $stable(pin_out) && $stable(pin_oe));
  assert_unmapped_rd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_we && !hit_any) |=> bus_rdata == 32'h0);
endmodule

// File: tb/gpio_bank_regs_bench.sv
module gpio_bank_regs_bench;
  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe;
  logic        bus_ready;
  int checks = 0, errors = 0, reqs = 0, acks = 0;
  bit done = 0;

  logic        q_rd[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  gpio_bank_regs u_gpio_bank_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input bit we, input logic [11:0] a, input logic [31:0] d,
                      input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_we = we; bus_addr = a; bus_wdata = d;
    q_rd.push_back(!we); q_exp.push_back(exp); q_tag.push_back(tag);
    reqs++;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  always @(negedge clk) begin
    if (bus_ready) begin
      acks++;
      if (q_rd.size() == 0) chk(0, "R9 ready without request", 1, 0);
      else begin
        logic r; logic [31:0] e; string t;
        r = q_rd.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
        if (r) chk(bus_rdata === e, t, bus_rdata, e);
      end
    end
  end

  initial begin
    repeat (400) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    chk(pin_out === 0, "R1 pin_out", pin_out, 0);
    chk(pin_oe === 0, "R1 pin_oe", pin_oe, 0);
    xfer(0, 12'h040, 0, 32'h0, "R1 out reg");
    xfer(0, 12'h204, 0, 32'h0, "R1 dir reg");
    xfer(0, 12'h208, 0, 32'h0, "R1 oen reg");

    xfer(1, 12'h040, 32'hA5A5_0F0F, 0, "");
    xfer(0, 12'h040, 0, 32'hA5A5_0F0F, "R4 full readback");
    chk(pin_out === 32'hA5A5_0F0F, "R4 pin_out", pin_out, 32'hA5A5_0F0F);

    xfer(1, 12'h000, 32'hFF00_00FF, 0, "");
    xfer(0, 12'h040, 0, 32'hA5A5_0FFF, "R2 partial mask");
    xfer(1, 12'h000, 32'hFFFE_0000, 0, "");
    chk(pin_out === 32'hA5A5_0FFE, "R2 single pin", pin_out, 32'hA5A5_0FFE);
    xfer(0, 12'h000, 0, 32'h0, "R2 masked port reads 0");

    xfer(1, 12'h004, 32'h00FF_1234, 0, "");
    chk(pin_out === 32'h12A5_0FFE, "R3 partial mask", pin_out, 32'h12A5_0FFE);
    xfer(1, 12'h004, 32'hFFFF_0000, 0, "");
    chk(pin_out === 32'h12A5_0FFE, "R3 full mask keeps", pin_out, 32'h12A5_0FFE);

    xfer(1, 12'h204, 32'h0000_FFFF, 0, "");
    chk(pin_oe === 0, "R6 dir only", pin_oe, 0);
    xfer(1, 12'h208, 32'h00FF_00FF, 0, "");
    chk(pin_oe === 32'h0000_00FF, "R6 dir and oen", pin_oe, 32'h0000_00FF);
    xfer(0, 12'h204, 0, 32'h0000_FFFF, "R5 dir readback");
    xfer(0, 12'h208, 0, 32'h00FF_00FF, "R5 oen readback");
    xfer(1, 12'h204, 32'h0, 0, "");
    chk(pin_oe === 0, "R6 oen only", pin_oe, 0);

    @(negedge clk) pin_in = 32'hDEAD_BEEF;
    xfer(0, 12'h060, 0, 32'h0, "R7 not seen after one edge");
    xfer(0, 12'h060, 0, 32'hDEAD_BEEF, "R7 synchronized level");
    xfer(1, 12'h060, 32'h0, 0, "");
    xfer(0, 12'h060, 0, 32'hDEAD_BEEF, "R7 write ignored");

    xfer(1, 12'h0C0, 32'hFFFF_FFFF, 0, "");
    xfer(1, 12'h008, 32'h0000_0000, 0, "");
    xfer(1, 12'h248, 32'hFFFF_FFFF, 0, "");
    chk(pin_out === 32'h12A5_0FFE, "R8 pin_out unchanged", pin_out, 32'h12A5_0FFE);
    chk(pin_oe === 0, "R8 pin_oe unchanged", pin_oe, 0);
    xfer(0, 12'h0C0, 0, 32'h0, "R8 unmapped read");
    xfer(0, 12'h100, 0, 32'h0, "R8 unmapped read 2");
    xfer(0, 12'h044, 0, 32'h0, "R8 other bank read");

    repeat (3) @(negedge clk);
    chk(acks == reqs && q_rd.size() == 0, "R9 one ready per request", acks, reqs);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule